// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block sits between the protection monitors of a three-phase gate driver and the pins and registers the system controller sees. Each monitor supplies a condition line. The block sorts the events into classes and applies a different rule to each class. Latched faults hold the fault pin low and ask the gate stage to pull every output low. Warnings make the fault pin blink until the controller reads the main status word. Real-time flags only mirror the live condition. One group of sources, the per-FET drain-source monitors, can be switched between latched, report-only and not reported.

The block also contains a controller watchdog. The read of the main status word that acknowledges warnings also restarts the watchdog timer. When the timer expires, the watchdog raises a latched fault, drops power-good for 64 µs and disarms itself. Latched faults are cleared by a rising edge on the gate-enable input or by a self-clearing clear request. The clock frequency is a parameter, and every µs and ms interval is derived from it.

Top module: `mfs_top`

## Requirements
- R1: A latched-source event, even a single-cycle pulse, sets its bit in `status_lat[NL-1:0]` from the next clock edge. It holds `fault_n` low and `gate_pd` high until a clear.
- R2: A new warning-source bit, or a new drain-source bit in report mode, makes `fault_n` go low at the edge that captures it. The pin then toggles every 32 µs (low first) until a read with `rd_addr` = 4'h1 is accepted. After that read the pin returns high.
- R3: A read with `rd_addr` = 4'h1 clears a warning bit (`status_main[NW-1:0]`) only if its condition is absent at that edge; otherwise the bit stays set. A read of any other address leaves the bit set.
- R4: A rising edge of `gate_en` clears latched and warning bits at that edge. A `clr_req` pulse raises `clr_busy` for exactly one cycle, and the clear takes effect at the edge that drops `clr_busy`. A bit whose condition is still present stays set.
- R5: Real-time bits `status_main[NW+NT-1:NW]` equal the condition lines sampled one edge earlier and never change `fault_n`.
- R6: `rpt_mode` sets the class of the drain-source events: 2'b00 latched (as R1), 2'b01 report-only (blinking as R2, cleared by reads as R3), 2'b10 and 2'b11 not reported (no status bit and no effect on `fault_n`).
- R7: The watchdog is disarmed after reset. A `wd_arm` pulse arms it with `wd_sel` 2'b00/01/10/11 selecting 10/20/50/100 ms. If the timer is not restarted, the watchdog fault sets exactly that many clock cycles after the arming edge.
- R8: An accepted read of address 4'h1 while armed restarts the full interval from that edge.
- R9: Watchdog expiry sets `status_lat[NL+NR]`, clears `wd_en` and drops `pgood` for exactly 64 µs.
- R10: `status_main[NW+NT+1]` is 1 while any latched-class fault is held and 0 when only warnings are present.
- R11: With a latched fault and a warning both active, `fault_n` stays steadily low.
- R12: `gate_pd` is high whenever `gate_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Gate-enable pin, synchronous; rising edge clears faults |
| lat_in | input | NL | Latched-class condition lines |
| warn_in | input | NW | Warning-class condition lines |
| rpt_in | input | NR | Drain-source monitor conditions, class set by `rpt_mode` |
| rpt_mode | input | 2 | 00 latched, 01 report-only, 1x not reported |
| rt_in | input | NT | Real-time condition lines |
| rd_stb | input | 1 | Register read accepted this cycle |
| rd_addr | input | 4 | Address of the read |
| clr_req | input | 1 | Clear-faults bit written to 1 |
| wd_arm | input | 1 | Watchdog enable written to 1 |
| wd_sel | input | 2 | Watchdog interval selection, sampled on `wd_arm` |
| status_main | output | NW+NT+2 | {fault kind, report-any, real-time, warnings} |
| status_lat | output | NL+NR+1 | {watchdog fault, drain-source bits, latched bits} |
| clr_busy | output | 1 | Read-back of the clear bit; self-clears |
| wd_en | output | 1 | Watchdog armed |
| fault_n | output | 1 | Fault pin level; 0 means pull the open drain low |
| pgood | output | 1 | Power-good |
| gate_pd | output | 1 | Request to pull all gate outputs low |

## Verification
A wrong pending or phase register shows up on `fault_n` within one 32 µs half period, as a missing toggle or a pin that stays high. A stuck or miscounting watchdog prescaler moves the fault-set edge off its exact cycle, and a single edge of sampling at the expected expiry cycle catches it. A clear that runs at the wrong time shows in the status words one edge early or late, and a bit that does not re-latch under a live condition shows at the same edge.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [1:0] {
    SRC_LATCH  = 2'b00,
    SRC_REPORT = 2'b01,
    SRC_OFF_A  = 2'b10,
    SRC_OFF_B  = 2'b11
  } src_mode_e;

  localparam logic [3:0] MAIN_ADDR = 4'h1;

  // Watchdog interval in milliseconds for each selection code.
  function automatic logic [6:0] wd_limit_ms(input logic [1:0] sel);
    case (sel)
      2'b00:   wd_limit_ms = 7'd10;
      2'b01:   wd_limit_ms = 7'd20;
      2'b10:   wd_limit_ms = 7'd50;
      default: wd_limit_ms = 7'd100;
    endcase
  endfunction

endpackage

// File: rtl/mfs_event_bank.sv
module mfs_event_bank
  import mfs_pkg::*;
#(
  parameter int NL = 4,
  parameter int NW = 4,
  parameter int NR = 6,
  parameter int NT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lat_in,
  input  logic [NW-1:0] warn_in,
  input  logic [NR-1:0] rpt_in,
  input  logic [NT-1:0] rt_in,
  input  logic [1:0]    rpt_mode,
  input  logic          rd_main,
  input  logic          clr_now,
  output logic [NL-1:0] lat_q,
  output logic [NW-1:0] warn_q,
  output logic [NR-1:0] rpt_q,
  output logic [NT-1:0] rt_q,
  output logic          rpt_latched,
  output logic          new_warn
);

  src_mode_e   mode;
  logic        mode_latch, mode_rep;
  logic [NR-1:0] rpt_set;
  logic [NL-1:0] lat_nxt;
  logic [NW-1:0] warn_nxt;
  logic [NR-1:0] rpt_nxt;

  always_comb begin
    mode       = src_mode_e'(rpt_mode);
    mode_latch = (mode == SRC_LATCH);
    mode_rep   = (mode == SRC_REPORT);
    rpt_set    = (mode_latch || mode_rep) ? rpt_in : '0;

    lat_nxt  = clr_now ? lat_in : (lat_q | lat_in);
    warn_nxt = (clr_now || rd_main) ? warn_in : (warn_q | warn_in);

    if (clr_now)
      rpt_nxt = rpt_set;
    else if (rd_main && mode_rep)
      rpt_nxt = rpt_set;
    else
      rpt_nxt = rpt_q | rpt_set;
  end

  assign new_warn    = (|(warn_in & ~warn_q)) || (mode_rep && (|(rpt_set & ~rpt_q)));
  assign rpt_latched = mode_latch && (|rpt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      warn_q <= '0;
      rpt_q  <= '0;
      rt_q   <= '0;
    end else begin
      lat_q  <= lat_nxt;
      warn_q <= warn_nxt;
      rpt_q  <= rpt_nxt;
      rt_q   <= rt_in;
    end
  end

endmodule

// File: rtl/mfs_pin_blink.sv
module mfs_pin_blink #(
  parameter int HALF_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic new_warn,
  input  logic ack,
  input  logic hold_low,
  output logic fault_n
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          pend;
  logic          phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      phase <= 1'b0;
      cnt   <= '0;
    end else if (new_warn) begin
      pend  <= 1'b1;
      phase <= 1'b0;
      cnt   <= '0;
    end else if (ack) begin
      pend  <= 1'b0;
      phase <= 1'b0;
      cnt   <= '0;
    end else if (pend) begin
      if (cnt == CW'(HALF_CYC - 1)) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (hold_low)
      fault_n = 1'b0;
    else if (pend)
      fault_n = phase;
    else
      fault_n = 1'b1;
  end

endmodule

// File: rtl/mfs_watchdog.sv
module mfs_watchdog
  import mfs_pkg::*;
#(
  parameter int MS_CYC = 250000,
  parameter int PG_CYC = 16000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [1:0] sel,
  input  logic       kick,
  input  logic       clr,
  output logic       en_o,
  output logic       fault_o,
  output logic       pgood_o
);

  localparam int PW = (MS_CYC > 1) ? $clog2(MS_CYC) : 1;
  localparam int GW = $clog2(PG_CYC + 1);

  logic          en;
  logic [1:0]    sel_q;
  logic [PW-1:0] pre;
  logic [6:0]    ms_cnt;
  logic          fault;
  logic [GW-1:0] pg_cnt;
  logic          ms_tick, expire;
  logic [6:0]    lim;

  assign lim     = wd_limit_ms(sel_q);
  assign ms_tick = en && !arm && !kick && (pre == PW'(MS_CYC - 1));
  assign expire  = ms_tick && (ms_cnt == lim - 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      sel_q  <= 2'b01;
      pre    <= '0;
      ms_cnt <= '0;
    end else if (arm) begin
      en     <= 1'b1;
      sel_q  <= sel;
      pre    <= '0;
      ms_cnt <= '0;
    end else if (en) begin
      if (kick) begin
        pre    <= '0;
        ms_cnt <= '0;
      end else if (ms_tick) begin
        pre <= '0;
        if (expire) begin
          en     <= 1'b0;
          ms_cnt <= '0;
        end else begin
          ms_cnt <= ms_cnt + 7'd1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault  <= 1'b0;
      pg_cnt <= '0;
    end else begin
      if (expire)
        fault <= 1'b1;
      else if (clr)
        fault <= 1'b0;

      if (expire)
        pg_cnt <= GW'(PG_CYC);
      else if (pg_cnt != '0)
        pg_cnt <= pg_cnt - 1'b1;
    end
  end

  assign en_o    = en;
  assign fault_o = fault;
  assign pgood_o = (pg_cnt == '0);

endmodule

// File: rtl/mfs_top.sv
module mfs_top
  import mfs_pkg::*;
#(
  parameter int CLK_HZ    = 250_000_000,
  parameter int US_PER_MS = 1000,
  parameter int NL        = 4,
  parameter int NW        = 4,
  parameter int NR        = 6,
  parameter int NT        = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gate_en,
  input  logic [NL-1:0]       lat_in,
  input  logic [NW-1:0]       warn_in,
  input  logic [NR-1:0]       rpt_in,
  input  logic [1:0]          rpt_mode,
  input  logic [NT-1:0]       rt_in,
  input  logic                rd_stb,
  input  logic [3:0]          rd_addr,
  input  logic                clr_req,
  input  logic                wd_arm,
  input  logic [1:0]          wd_sel,
  output logic [NW+NT+1:0]    status_main,
  output logic [NL+NR:0]      status_lat,
  output logic                clr_busy,
  output logic                wd_en,
  output logic                fault_n,
  output logic                pgood,
  output logic                gate_pd
);

  localparam int CYC_RAW    = CLK_HZ / 1_000_000;
  localparam int CYC_PER_US = (CYC_RAW > 0) ? CYC_RAW : 1;
  localparam int MS_CYC     = CYC_PER_US * US_PER_MS;
  localparam int PG_CYC     = CYC_PER_US * 64;
  localparam int HALF_CYC   = CYC_PER_US * 32;

  logic          gate_en_q;
  logic          en_rise;
  logic          busy_q;
  logic          clr_now;
  logic          rd_main;
  logic [NL-1:0] lat_q;
  logic [NW-1:0] warn_q;
  logic [NR-1:0] rpt_q;
  logic [NT-1:0] rt_q;
  logic          rpt_latched;
  logic          new_warn;
  logic          wd_fault;
  logic          lat_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      gate_en_q <= gate_en;
      busy_q    <= clr_req && !busy_q;
    end
  end

  assign en_rise = gate_en && !gate_en_q;
  assign clr_now = busy_q || en_rise;
  assign rd_main = rd_stb && (rd_addr == MAIN_ADDR);

  mfs_event_bank #(
    .NL(NL), .NW(NW), .NR(NR), .NT(NT)
  ) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_in     (lat_in),
    .warn_in    (warn_in),
    .rpt_in     (rpt_in),
    .rt_in      (rt_in),
    .rpt_mode   (rpt_mode),
    .rd_main    (rd_main),
    .clr_now    (clr_now),
    .lat_q      (lat_q),
    .warn_q     (warn_q),
    .rpt_q      (rpt_q),
    .rt_q       (rt_q),
    .rpt_latched(rpt_latched),
    .new_warn   (new_warn)
  );

  mfs_watchdog #(
    .MS_CYC(MS_CYC), .PG_CYC(PG_CYC)
  ) wdog_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (wd_arm),
    .sel    (wd_sel),
    .kick   (rd_main),
    .clr    (clr_now),
    .en_o   (wd_en),
    .fault_o(wd_fault),
    .pgood_o(pgood)
  );

  assign lat_active = (|lat_q) || wd_fault || rpt_latched;

  mfs_pin_blink #(
    .HALF_CYC(HALF_CYC)
  ) pin_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .new_warn(new_warn),
    .ack     (rd_main || clr_now),
    .hold_low(lat_active),
    .fault_n (fault_n)
  );

  assign status_main = {lat_active, |rpt_q, rt_q, warn_q};
  assign status_lat  = {wd_fault, rpt_q, lat_q};
  assign clr_busy    = busy_q;
  assign gate_pd     = lat_active || !gate_en;

endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
  parameter int NL = 4,
  parameter int NW = 4,
  parameter int NR = 6,
  parameter int NT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic [NT-1:0]    rt_in,
  input logic [NW+NT+1:0] status_main,
  input logic [NL+NR:0]   status_lat,
  input logic             clr_busy,
  input logic             wd_en,
  input logic             fault_n,
  input logic             pgood,
  input logic             gate_pd
);

  localparam int SW = NW + NT + 2;
  localparam int LW = NL + NR + 1;

  logic hard;
  assign hard = (|status_lat[NL-1:0]) || status_lat[LW-1];

  p_lat_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_lat[NL-1:0]) |-> (!fault_n && gate_pd));

  p_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hard |-> !fault_n);

  p_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hard |-> status_main[SW-1]);

  p_self_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> !clr_busy);

  p_rt_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_main[NW+NT-1:NW] == $past(rt_in)));

  p_wd_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_lat[LW-1]) |-> (!wd_en && !pgood));

  p_pg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood) |=> !pgood);

  p_pd_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> gate_pd);

endmodule

bind mfs_top mfs_checker #(.NL(NL), .NW(NW), .NR(NR), .NT(NT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_en    (gate_en),
  .rt_in      (rt_in),
  .status_main(status_main),
  .status_lat (status_lat),
  .clr_busy   (clr_busy),
  .wd_en      (wd_en),
  .fault_n    (fault_n),
  .pgood      (pgood),
  .gate_pd    (gate_pd)
);

// File: tb/mfs_top_tb_top.sv
module mfs_top_tb_top;

  localparam int CLK_HZ = 1_000_000;   // one cycle per microsecond
  localparam int UPM    = 4;           // scaled millisecond
  localparam int NL = 4, NW = 4, NR = 6, NT = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             gate_en = 1'b1;
  logic [NL-1:0]    lat_in = '0;
  logic [NW-1:0]    warn_in = '0;
  logic [NR-1:0]    rpt_in = '0;
  logic [1:0]       rpt_mode = 2'b01;
  logic [NT-1:0]    rt_in = '0;
  logic             rd_stb = 1'b0;
  logic [3:0]       rd_addr = 4'h0;
  logic             clr_req = 1'b0;
  logic             wd_arm = 1'b0;
  logic [1:0]       wd_sel = 2'b00;
  logic [NW+NT+1:0] status_main;
  logic [NL+NR:0]   status_lat;
  logic             clr_busy, wd_en, fault_n, pgood, gate_pd;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  mfs_top #(.CLK_HZ(CLK_HZ), .US_PER_MS(UPM), .NL(NL), .NW(NW), .NR(NR), .NT(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .lat_in(lat_in), .warn_in(warn_in),
    .rpt_in(rpt_in), .rpt_mode(rpt_mode), .rt_in(rt_in), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .clr_req(clr_req), .wd_arm(wd_arm), .wd_sel(wd_sel), .status_main(status_main),
    .status_lat(status_lat), .clr_busy(clr_busy), .wd_en(wd_en), .fault_n(fault_n),
    .pgood(pgood), .gate_pd(gate_pd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [3:0] a);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    chk("R4 clr_busy raised", clr_busy, 1);
    tick(1);
    chk("R4 clr_busy self-cleared", clr_busy, 0);
  endtask

  task automatic en_toggle();
    @(negedge clk); gate_en = 1'b0;
    @(negedge clk);
    chk("R12 gate_pd with enable low", gate_pd, 1);
    gate_en = 1'b1;
    @(negedge clk);
  endtask

  function automatic int lim_ms(input int s);
    return (s == 0) ? 10 : (s == 1) ? 20 : (s == 2) ? 50 : 100;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("reset fault_n", fault_n, 1);
    chk("reset pgood", pgood, 1);
    chk("reset status_main", status_main, 0);
    chk("reset status_lat", status_lat, 0);
    chk("R7 watchdog off after reset", wd_en, 0);
    chk("R12 gate_pd idle", gate_pd, 0);

    // R7: never armed, never expires
    tick(500);
    chk("R7 no expiry when disarmed", status_lat[NL+NR], 0);

    // R1 / R4 / R10: latched sources, alternating clear methods
    for (int i = 0; i < NL; i++) begin
      @(negedge clk); lat_in[i] = 1'b1;
      @(negedge clk); lat_in[i] = 1'b0;
      chk("R1 latched bit", status_lat, 32'(1) << i);
      chk("R1 fault_n low", fault_n, 0);
      chk("R1 gate_pd", gate_pd, 1);
      chk("R10 kind bit", status_main[NW+NT+1], 1);
      tick(40);
      chk("R1 still low", fault_n, 0);
      if (i % 2 == 0) do_clr(); else en_toggle();
      chk("R4 cleared", status_lat, 0);
      chk("R4 pin released", fault_n, 1);
    end

    // R4: live condition re-latches
    @(negedge clk); lat_in[0] = 1'b1;
    do_clr();
    chk("R4 persists while live", status_lat[0], 1);
    lat_in[0] = 1'b0;
    do_clr();
    chk("R4 clears after drop", status_lat[0], 0);

    // R2 / R3 / R10: each warning source
    for (int i = 0; i < NW; i++) begin
      @(negedge clk); warn_in[i] = 1'b1;
      @(negedge clk);
      chk("R2 first phase low", fault_n, 0);
      chk("R10 kind bit for warning", status_main[NW+NT+1], 0);
      chk("R3 warn bit set", status_main[i], 1);
      tick(31); chk("R2 low to 32us", fault_n, 0);
      tick(1);  chk("R2 high after 32us", fault_n, 1);
      tick(31); chk("R2 high to 64us", fault_n, 1);
      tick(1);  chk("R2 low after 64us", fault_n, 0);
      do_read(4'h1);
      chk("R2 ack stops blink", fault_n, 1);
      chk("R3 live bit kept", status_main[i], 1);
      warn_in[i] = 1'b0;
      do_read(4'h2);
      chk("R3 other address keeps bit", status_main[i], 1);
      do_read(4'h1);
      chk("R3 cleared after drop", status_main[NW-1:0], 0);
    end

    // R5: exhaustive real-time patterns
    for (int v = 0; v < (1 << NT); v++) begin
      @(negedge clk); rt_in = NT'(v);
      @(negedge clk);
      chk("R5 rt mirror", status_main[NW+NT-1:NW], v);
      chk("R5 fault_n untouched", fault_n, 1);
    end
    rt_in = '0;

    // R6: drain-source classes
    for (int j = 0; j < NR; j++) begin
      rpt_mode = 2'b00;
      @(negedge clk); rpt_in[j] = 1'b1;
      @(negedge clk); rpt_in[j] = 1'b0;
      chk("R6 latch-mode bit", status_lat, 32'(1) << (NL + j));
      chk("R6 latch-mode pin", fault_n, 0);
      chk("R6 latch-mode kind", status_main[NW+NT+1], 1);
      tick(40);
      chk("R6 latch-mode steady", fault_n, 0);
      do_clr();

      rpt_mode = 2'b01;
      @(negedge clk); rpt_in[j] = 1'b1;
      @(negedge clk);
      chk("R6 report pin low", fault_n, 0);
      chk("R6 report summary", status_main[NW+NT+1:NW+NT], 2'b01);
      tick(32);
      chk("R6 report blink high", fault_n, 1);
      rpt_in[j] = 1'b0;
      do_read(4'h1);
      chk("R6 report cleared by read", status_lat, 0);
      chk("R6 report ack", fault_n, 1);

      rpt_mode = (j % 2 == 0) ? 2'b10 : 2'b11;
      @(negedge clk); rpt_in[j] = 1'b1;
      @(negedge clk); rpt_in[j] = 1'b0;
      tick(1);
      chk("R6 ignored no bit", status_lat, 0);
      chk("R6 ignored no pin", fault_n, 1);
    end
    rpt_mode = 2'b01;

    // R11: latched plus warning
    begin
      logic seen_high;
      seen_high = 1'b0;
      @(negedge clk); lat_in[1] = 1'b1; warn_in[2] = 1'b1;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (fault_n !== 1'b0) seen_high = 1'b1;
      end
      chk("R11 steady low with both", seen_high, 0);
      lat_in = '0; warn_in = '0;
      do_clr();
      chk("R11 both cleared", {status_lat, status_main}, 0);
      chk("R11 pin released", fault_n, 1);
    end

    // R7 / R9: every interval
    for (int s = 0; s < 4; s++) begin
      int cyc;
      cyc = lim_ms(s) * UPM * (CLK_HZ / 1_000_000);
      @(negedge clk); wd_arm = 1'b1; wd_sel = 2'(s);
      @(negedge clk); wd_arm = 1'b0;
      chk("R7 armed", wd_en, 1);
      tick(cyc - 1);
      chk("R7 not yet expired", status_lat[NL+NR], 0);
      chk("R7 pgood before expiry", pgood, 1);
      tick(1);
      chk("R7 expired on time", status_lat[NL+NR], 1);
      chk("R9 enable dropped", wd_en, 0);
      chk("R9 pgood low", pgood, 0);
      chk("R10 watchdog kind", status_main[NW+NT+1], 1);
      chk("R9 fault pin", fault_n, 0);
      tick(63);
      chk("R9 pgood still low", pgood, 0);
      tick(1);
      chk("R9 pgood back after 64us", pgood, 1);
      do_clr();
      chk("R9 watchdog fault cleared", status_lat[NL+NR], 0);
    end

    // R8: status read restarts the interval
    @(negedge clk); wd_arm = 1'b1; wd_sel = 2'b00;
    @(negedge clk); wd_arm = 1'b0;
    tick(29);
    do_read(4'h1);
    tick(39);
    chk("R8 restarted, no expiry", status_lat[NL+NR], 0);
    tick(1);
    chk("R8 expiry after restart", status_lat[NL+NR], 1);
    en_toggle();
    chk("R4 enable edge clears watchdog fault", status_lat[NL+NR], 0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule